// File: doc/BRIEF.md
# Inverted Page Table Lookup Engine

This block translates a (process ID, virtual page number) pair into a physical frame number by searching an inverted page table. That table has exactly one entry per physical frame, so its size follows installed memory and not the width of the virtual address. Each entry carries a valid flag, a process tag, a page tag and a link to the next entry. Because every frame has a single owner tag, two virtual pages can never resolve to the same frame through this table.

A lookup starts when a request is accepted. The engine folds the key into a bucket index with XOR and reads that bucket's head pointer from a bucket table. It then reads frame entries along the collision chain through a second read port. It stops at the first entry whose tags match, at a chain terminator, or at a fixed probe limit. The frame number it returns is the position of the matching entry in the table.

Both tables live outside the block behind synchronous read ports with one cycle of latency. They are filled by other logic. The engine handles one lookup at a time.

Top module: `ipt_lookup`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `req_ready` is 1 and `anchor_rd_en`, `entry_rd_en` and `rsp_valid` are all 0.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` both 1 at a clock edge), `anchor_rd_en` is 1 for exactly one cycle. `anchor_rd_addr` is then the XOR fold of the key {`req_pid`, `req_vpn`}, with the page number in the low bits: key bit i is XORed into address bit (i mod ANCHOR_W).
- R3: A bucket word of all ones marks an empty bucket. The response then comes two cycles after the bucket read, with `rsp_hit`=0 and `rsp_frame`=0. Every miss, whatever its cause, reports `rsp_frame`=0.
- R4: A bucket word other than all ones is the index of the first entry. That entry is read (`entry_rd_en` for one cycle) two cycles after the bucket read. Each further entry is read two cycles after the previous one, and the bucket port and entry port are never active in the same cycle.
- R5: An entry matches when its valid flag is 1 and both its process tag and its page tag equal the key. On a match, `rsp_valid` pulses for one cycle two cycles after that entry's read, with `rsp_hit`=1 and `rsp_frame` equal to the index of that entry.
- R6: An entry that does not match is followed through its next field. A next field of all ones ends the chain, and the response (a miss) comes two cycles after that entry's read. An invalid entry never matches, but its next field is still followed.
- R7: A lookup reads at most MAX_PROBES entries. If the MAX_PROBES-th entry does not match and its next field is not all ones, the lookup ends as a miss two cycles after that read. A match on the MAX_PROBES-th entry is still a hit.
- R8: `req_ready` is 0 from the cycle after acceptance up to and including the cycle before the response. It returns to 1 in the response cycle. A `req_valid` raised while `req_ready` is 0 has no effect: no extra bucket read takes place and the lookup in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle; a request is taken at this edge |
| req_pid | input | PID_W | Process ID of the request |
| req_vpn | input | VPN_W | Virtual page number of the request |
| anchor_rd_en | output | 1 | Bucket table read strobe |
| anchor_rd_addr | output | ANCHOR_W | Bucket index |
| anchor_rd_data | input | FRAME_W | Head entry index, all ones for empty; valid the cycle after the strobe |
| entry_rd_en | output | 1 | Frame entry read strobe |
| entry_rd_addr | output | FRAME_W | Frame entry index |
| entry_rd_valid | input | 1 | Entry valid flag, valid the cycle after the strobe |
| entry_rd_pid | input | PID_W | Entry process tag |
| entry_rd_vpn | input | VPN_W | Entry page tag |
| entry_rd_next | input | FRAME_W | Next entry in the chain, all ones for end |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | 1 when a matching entry was found |
| rsp_frame | output | FRAME_W | Frame number of the match, 0 on a miss |

## Verification
The hardest condition to reach is the probe limit. A well-formed table never has a chain long enough to hit it, so the bench writes a table with two entries that point at each other. It also writes a chain of exactly MAX_PROBES entries and one of MAX_PROBES+1 entries, which cover both sides of the cut-off. Keys that collide are built by flipping two key bits that fold onto the same bucket bit. Invalid links, process-tag-only mismatches and requests raised while the engine is busy are injected on purpose. A randomly filled table then exercises ordinary short chains.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  // Walk phases: each table read takes one cycle to issue and one to evaluate
  typedef enum logic [2:0] {
    WS_IDLE,
    WS_ANC_WAIT,
    WS_ANC_CHK,
    WS_ENT_WAIT,
    WS_ENT_CHK
  } walk_state_t;

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int IN_W  = 28,
  parameter int OUT_W = 5
) (
  input  logic [IN_W-1:0]  key_i,
  output logic [OUT_W-1:0] idx_o
);

  localparam int NCH   = (IN_W + OUT_W - 1) / OUT_W;
  localparam int PAD_W = NCH * OUT_W;

  logic [PAD_W-1:0] padded;
  logic [OUT_W-1:0] fold [NCH+1];

  assign padded  = PAD_W'(key_i);
  assign fold[0] = '0;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_fold
      assign fold[c+1] = fold[c] ^ padded[c*OUT_W +: OUT_W];
    end
  endgenerate

  assign idx_o = fold[NCH];

endmodule

// File: rtl/ipt_tag_cmp.sv
module ipt_tag_cmp #(
  parameter int PID_W   = 8,
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 6
) (
  input  logic [PID_W-1:0]   key_pid_i,
  input  logic [VPN_W-1:0]   key_vpn_i,
  input  logic               ent_valid_i,
  input  logic [PID_W-1:0]   ent_pid_i,
  input  logic [VPN_W-1:0]   ent_vpn_i,
  input  logic [FRAME_W-1:0] ent_next_i,
  output logic               hit_o,
  output logic               last_o
);

  localparam logic [FRAME_W-1:0] NULL_IDX = {FRAME_W{1'b1}};

  assign hit_o  = ent_valid_i && (ent_pid_i == key_pid_i) && (ent_vpn_i == key_vpn_i);
  assign last_o = (ent_next_i == NULL_IDX);

endmodule

// File: rtl/ipt_walk_ctrl.sv
module ipt_walk_ctrl
  import ipt_pkg::*;
#(
  parameter int PID_W      = 8,
  parameter int VPN_W      = 20,
  parameter int FRAME_W    = 6,
  parameter int ANCHOR_W   = 5,
  parameter int MAX_PROBES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PID_W-1:0]    req_pid,
  input  logic [VPN_W-1:0]    req_vpn,
  input  logic [ANCHOR_W-1:0] req_hash,
  output logic [PID_W-1:0]    key_pid_o,
  output logic [VPN_W-1:0]    key_vpn_o,
  output logic                anchor_rd_en,
  output logic [ANCHOR_W-1:0] anchor_rd_addr,
  input  logic [FRAME_W-1:0]  anchor_rd_data,
  output logic                entry_rd_en,
  output logic [FRAME_W-1:0]  entry_rd_addr,
  input  logic [FRAME_W-1:0]  entry_rd_next,
  input  logic                tag_hit,
  input  logic                tag_last,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [FRAME_W-1:0]  rsp_frame
);

  localparam int CNT_W = $clog2(MAX_PROBES + 1);
  localparam logic [FRAME_W-1:0] NULL_IDX  = {FRAME_W{1'b1}};
  localparam logic [CNT_W-1:0]   PROBE_MAX = CNT_W'(MAX_PROBES);

  walk_state_t      state;
  logic [CNT_W-1:0] probe_cnt;

  assign req_ready = (state == WS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= WS_IDLE;
      probe_cnt      <= '0;
      key_pid_o      <= '0;
      key_vpn_o      <= '0;
      anchor_rd_en   <= 1'b0;
      anchor_rd_addr <= '0;
      entry_rd_en    <= 1'b0;
      entry_rd_addr  <= '0;
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_frame      <= '0;
    end else begin
      anchor_rd_en <= 1'b0;
      entry_rd_en  <= 1'b0;
      rsp_valid    <= 1'b0;
      case (state)
        WS_IDLE: begin
          if (req_valid) begin
            key_pid_o      <= req_pid;
            key_vpn_o      <= req_vpn;
            anchor_rd_addr <= req_hash;
            anchor_rd_en   <= 1'b1;
            state          <= WS_ANC_WAIT;
          end
        end
        WS_ANC_WAIT: state <= WS_ANC_CHK;
        WS_ANC_CHK: begin
          if (anchor_rd_data == NULL_IDX) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_frame <= '0;
            state     <= WS_IDLE;
          end else begin
            entry_rd_en   <= 1'b1;
            entry_rd_addr <= anchor_rd_data;
            probe_cnt     <= CNT_W'(1);
            state         <= WS_ENT_WAIT;
          end
        end
        WS_ENT_WAIT: state <= WS_ENT_CHK;
        WS_ENT_CHK: begin
          if (tag_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_frame <= entry_rd_addr;
            state     <= WS_IDLE;
          end else if (tag_last || (probe_cnt == PROBE_MAX)) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_frame <= '0;
            state     <= WS_IDLE;
          end else begin
            entry_rd_en   <= 1'b1;
            entry_rd_addr <= entry_rd_next;
            probe_cnt     <= probe_cnt + CNT_W'(1);
            state         <= WS_ENT_WAIT;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int PID_W      = 8,
  parameter int VPN_W      = 20,
  parameter int FRAME_W    = 6,
  parameter int ANCHOR_W   = 5,
  parameter int MAX_PROBES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PID_W-1:0]    req_pid,
  input  logic [VPN_W-1:0]    req_vpn,
  output logic                anchor_rd_en,
  output logic [ANCHOR_W-1:0] anchor_rd_addr,
  input  logic [FRAME_W-1:0]  anchor_rd_data,
  output logic                entry_rd_en,
  output logic [FRAME_W-1:0]  entry_rd_addr,
  input  logic                entry_rd_valid,
  input  logic [PID_W-1:0]    entry_rd_pid,
  input  logic [VPN_W-1:0]    entry_rd_vpn,
  input  logic [FRAME_W-1:0]  entry_rd_next,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [FRAME_W-1:0]  rsp_frame
);

  localparam int KEY_W = PID_W + VPN_W;

  logic [ANCHOR_W-1:0] req_hash;
  logic [PID_W-1:0]    key_pid;
  logic [VPN_W-1:0]    key_vpn;
  logic                tag_hit;
  logic                tag_last;

  ipt_hash #(.IN_W(KEY_W), .OUT_W(ANCHOR_W)) u_hash (
    .key_i ({req_pid, req_vpn}),
    .idx_o (req_hash)
  );

  ipt_tag_cmp #(.PID_W(PID_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_cmp (
    .key_pid_i   (key_pid),
    .key_vpn_i   (key_vpn),
    .ent_valid_i (entry_rd_valid),
    .ent_pid_i   (entry_rd_pid),
    .ent_vpn_i   (entry_rd_vpn),
    .ent_next_i  (entry_rd_next),
    .hit_o       (tag_hit),
    .last_o      (tag_last)
  );

  ipt_walk_ctrl #(
    .PID_W(PID_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W),
    .ANCHOR_W(ANCHOR_W), .MAX_PROBES(MAX_PROBES)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_pid        (req_pid),
    .req_vpn        (req_vpn),
    .req_hash       (req_hash),
    .key_pid_o      (key_pid),
    .key_vpn_o      (key_vpn),
    .anchor_rd_en   (anchor_rd_en),
    .anchor_rd_addr (anchor_rd_addr),
    .anchor_rd_data (anchor_rd_data),
    .entry_rd_en    (entry_rd_en),
    .entry_rd_addr  (entry_rd_addr),
    .entry_rd_next  (entry_rd_next),
    .tag_hit        (tag_hit),
    .tag_last       (tag_last),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_frame      (rsp_frame)
  );

endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int FRAME_W    = 6,
  parameter int MAX_PROBES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               anchor_rd_en,
  input logic               entry_rd_en,
  input logic [FRAME_W-1:0] entry_rd_addr,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [FRAME_W-1:0] rsp_frame
);

  localparam int RC_W = $clog2(MAX_PROBES + 2);

  logic [RC_W-1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (rst) rd_cnt <= '0;
    else if (req_valid && req_ready) rd_cnt <= '0;
    else if (entry_rd_en) rd_cnt <= rd_cnt + RC_W'(1);
  end

  AST_ACCEPT_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> anchor_rd_en);                                   // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_frame == '0));                               // R3
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(anchor_rd_en && entry_rd_en));                                              // R4
  AST_READ_GAP: assert property (@(posedge clk) disable iff (rst)
    entry_rd_en |=> (!entry_rd_en && !rsp_valid));                                // R4
  AST_HIT_FRAME: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_frame == $past(entry_rd_addr, 2)));           // R5
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);                                                    // R5
  AST_PROBE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= RC_W'(MAX_PROBES));                                                 // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (anchor_rd_en || entry_rd_en) |-> !req_ready);                                // R8

endmodule

bind ipt_lookup ipt_lookup_chk #(.FRAME_W(FRAME_W), .MAX_PROBES(MAX_PROBES)) u_chk (.*);

// File: tb/ipt_lookup_test.sv
module ipt_lookup_test;

  localparam int CLK_PERIOD = 10;
  localparam int PID_W      = 8;
  localparam int VPN_W      = 20;
  localparam int FRAME_W    = 6;
  localparam int ANCHOR_W   = 5;
  localparam int MAX_PROBES = 8;
  localparam int NANC       = 1 << ANCHOR_W;
  localparam int NFR        = 1 << FRAME_W;
  localparam int NULLI      = NFR - 1;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [PID_W-1:0]    req_pid = '0;
  logic [VPN_W-1:0]    req_vpn = '0;
  logic                anchor_rd_en;
  logic [ANCHOR_W-1:0] anchor_rd_addr;
  logic [FRAME_W-1:0]  anchor_rd_data = '1;
  logic                entry_rd_en;
  logic [FRAME_W-1:0]  entry_rd_addr;
  logic                entry_rd_valid = 1'b0;
  logic [PID_W-1:0]    entry_rd_pid = '0;
  logic [VPN_W-1:0]    entry_rd_vpn = '0;
  logic [FRAME_W-1:0]  entry_rd_next = '1;
  logic                rsp_valid;
  logic                rsp_hit;
  logic [FRAME_W-1:0]  rsp_frame;

  ipt_lookup #(
    .PID_W(PID_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W),
    .ANCHOR_W(ANCHOR_W), .MAX_PROBES(MAX_PROBES)
  ) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // table storage with one-cycle synchronous read
  logic [FRAME_W-1:0] anc_mem [NANC];
  logic               ent_v   [NFR];
  logic [PID_W-1:0]   ent_pid [NFR];
  logic [VPN_W-1:0]   ent_vpn [NFR];
  logic [FRAME_W-1:0] ent_nx  [NFR];

  always @(posedge clk) begin
    if (anchor_rd_en) anchor_rd_data <= anc_mem[anchor_rd_addr];
    if (entry_rd_en) begin
      entry_rd_valid <= ent_v[entry_rd_addr];
      entry_rd_pid   <= ent_pid[entry_rd_addr];
      entry_rd_vpn   <= ent_vpn[entry_rd_addr];
      entry_rd_next  <= ent_nx[entry_rd_addr];
    end
  end

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int href(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v);
    logic [PID_W+VPN_W-1:0] k;
    int h;
    k = {p, v};
    h = 0;
    for (int i = 0; i < PID_W + VPN_W; i++)
      if (k[i]) h = h ^ (1 << (i % ANCHOR_W));
    return h;
  endfunction

  // reference model state
  int    exp_anchor;
  int    exp_probe[$];
  bit    exp_hit;
  int    exp_frame;
  bit    active = 0;
  bit    chk_on = 0;
  int    off = 0;
  string cur_tag = "R5";

  task automatic model_walk(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v);
    int idx;
    exp_anchor = href(p, v);
    exp_probe.delete();
    exp_hit = 0;
    exp_frame = 0;
    idx = int'(anc_mem[exp_anchor]);
    if (idx != NULLI) begin
      forever begin
        exp_probe.push_back(idx);
        if (ent_v[idx] && ent_pid[idx] == p && ent_vpn[idx] == v) begin
          exp_hit = 1;
          exp_frame = idx;
          break;
        end
        if (int'(ent_nx[idx]) == NULLI) break;
        if (exp_probe.size() == MAX_PROBES) break;
        idx = int'(ent_nx[idx]);
      end
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      bit e_aen, e_een, e_rsp, e_rdy;
      int n;
      n = exp_probe.size();
      if (active) off++;
      e_aen = active && off == 1;
      e_een = active && off >= 3 && (off % 2) == 1 && ((off - 3) / 2) < n;
      e_rsp = active && off == 3 + 2 * n;
      e_rdy = !active || e_rsp;
      check(anchor_rd_en == e_aen, "R2 bucket strobe", anchor_rd_en, e_aen);
      if (e_aen) check(int'(anchor_rd_addr) == exp_anchor, "R2 bucket addr", anchor_rd_addr, exp_anchor);
      check(entry_rd_en == e_een, "R4 entry strobe", entry_rd_en, e_een);
      if (e_een) check(int'(entry_rd_addr) == exp_probe[(off - 3) / 2], "R6 entry addr",
                       entry_rd_addr, exp_probe[(off - 3) / 2]);
      check(rsp_valid == e_rsp, {cur_tag, " rsp strobe"}, rsp_valid, e_rsp);
      if (e_rsp) begin
        check(rsp_hit == exp_hit, {cur_tag, " hit"}, rsp_hit, exp_hit);
        check(int'(rsp_frame) == exp_frame, {cur_tag, " frame"}, rsp_frame, exp_frame);
        active = 0;
      end
      check(req_ready == e_rdy, "R8 ready", req_ready, e_rdy);
    end
  end

  task automatic lookup(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                        input string tag, input bit noise);
    while (active) @(posedge clk);
    @(posedge clk); #1;
    req_valid = 1'b1; req_pid = p; req_vpn = v;
    model_walk(p, v);
    cur_tag = tag;
    @(posedge clk); #1;
    req_valid = 1'b0;
    off = 0;
    active = 1;
    if (noise) begin
      // R8: request raised while busy must be ignored
      @(posedge clk); #1;
      req_valid = 1'b1; req_pid = ~p; req_vpn = ~v;
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
    while (active) @(posedge clk);
  endtask

  task automatic clear_table();
    for (int i = 0; i < NANC; i++) anc_mem[i] = '1;
    for (int i = 0; i < NFR; i++) begin
      ent_v[i] = 1'b0; ent_pid[i] = '0; ent_vpn[i] = '0; ent_nx[i] = '1;
    end
  endtask

  task automatic set_ent(input int f, input bit vld, input logic [PID_W-1:0] p,
                         input logic [VPN_W-1:0] v, input int nx);
    ent_v[f] = vld; ent_pid[f] = p; ent_vpn[f] = v; ent_nx[f] = FRAME_W'(nx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  logic [PID_W-1:0] rk_pid [40];
  logic [VPN_W-1:0] rk_vpn [40];

  initial begin
    logic [PID_W-1:0] p1;
    logic [VPN_W-1:0] v1;
    int h1;
    clear_table();
    p1 = 8'h12; v1 = 20'h0ABCD;
    h1 = href(p1, v1);

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    check(anchor_rd_en == 1'b0 && entry_rd_en == 1'b0, "R1 reads in reset", anchor_rd_en | entry_rd_en, 0);
    check(rsp_valid == 1'b0, "R1 rsp in reset", rsp_valid, 0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp after reset", rsp_valid, 0);
    chk_on = 1;

    // R3: empty bucket
    lookup(p1, v1, "R3", 0);

    // R5: single entry hit
    set_ent(5, 1, p1, v1, NULLI);
    anc_mem[h1] = 6'd5;
    lookup(p1, v1, "R5", 0);

    // R6: chain of colliding keys (bit pairs fold onto one bucket bit)
    set_ent(10, 1, p1, v1 ^ 20'h21, 20);
    set_ent(20, 1, p1, v1 ^ 20'h42, 62);
    set_ent(62, 1, p1, v1, NULLI);
    anc_mem[h1] = 6'd10;
    lookup(p1, v1, "R6 deep hit", 0);
    lookup(p1, v1 ^ 20'h42, "R8 busy ignore", 1);
    lookup(p1, v1 ^ 20'h63, "R6 chain end", 0);

    // R5: process tag differs only
    anc_mem[href(p1 ^ 8'h80, v1)] = 6'd62;
    lookup(p1 ^ 8'h80, v1, "R5 pid mismatch", 0);

    // R6: invalid entry skipped but followed
    clear_table();
    set_ent(62, 0, p1, v1, 7);
    set_ent(7, 1, p1, v1, NULLI);
    anc_mem[h1] = 6'd62;
    lookup(p1, v1, "R6 invalid skip", 0);

    // R7: loop in the table
    clear_table();
    set_ent(1, 1, p1, v1 ^ 20'h21, 2);
    set_ent(2, 1, p1, v1 ^ 20'h42, 1);
    anc_mem[h1] = 6'd1;
    lookup(p1, v1, "R7 loop", 0);

    // R7: exactly MAX_PROBES long, match on last
    clear_table();
    for (int i = 0; i < MAX_PROBES; i++)
      set_ent(30 + i, 1, p1 + 8'(i + 1), v1, 31 + i);
    set_ent(30 + MAX_PROBES - 1, 1, p1, v1, NULLI);
    anc_mem[h1] = 6'd30;
    lookup(p1, v1, "R7 last probe hit", 0);
    // one longer: match out of reach
    set_ent(30 + MAX_PROBES - 1, 1, p1 + 8'd99, v1, 30 + MAX_PROBES);
    set_ent(30 + MAX_PROBES, 1, p1, v1, NULLI);
    lookup(p1, v1, "R7 beyond limit", 0);

    // R5/R6: randomly filled table
    clear_table();
    for (int f = 0; f < 40; f++) begin
      int h;
      rk_pid[f] = PID_W'($urandom);
      rk_vpn[f] = VPN_W'($urandom);
      h = href(rk_pid[f], rk_vpn[f]);
      set_ent(f, 1, rk_pid[f], rk_vpn[f], int'(anc_mem[h]));
      anc_mem[h] = FRAME_W'(f);
    end
    for (int f = 0; f < 40; f++) lookup(rk_pid[f], rk_vpn[f], "R5 random", 0);
    for (int k = 0; k < 10; k++) lookup(PID_W'($urandom), VPN_W'($urandom), "R6 random", 0);

    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule